// File: doc/BRIEF.md
# Vector Floating-Point Exception and Issue Controller

This controller sits at the issue point of a pipelined single-precision vector floating-point unit. Arithmetic rounds to nearest-even only, and the arithmetic itself is outside this block. The controller accepts one instruction at a time. Each instruction carries an operation class and a vector length. The controller then steps through the instruction's elements one at a time. It tracks each element through a model of the unit's latency. When an element leaves the unit, the controller samples the IEEE status flags that the unit returns for it. It then drives a write of those flags into the per-element flag registers.

When the last element of an instruction leaves the unit, the controller may fire a single exception pulse. It does so if any element raised a flag that the exception mask leaves enabled. A user-writable mode input chooses when the next instruction may start:
- **Deferred mode:** issue runs at full rate, and errors are reported only at the end of each instruction.
- **Precise mode:** the next instruction is held at issue until the current instruction has fully completed and its exception has been reported.

Divides have a longer latency than the other operations. The divider also has a minimum spacing between operations, and the controller enforces that spacing in both modes.

Top module: `vfpx_ctrl`

## Requirements
- R1: After reset, `issue_stall`, both flag-write enables, `exc_raise` and `exc_cause` are all 0.
- R2: Suppose a simple-class instruction (`issue_cls` = 0: add, subtract, multiply, compare, convert) is accepted in cycle T, meaning `issue_valid`=1 and `issue_stall`=0 in that cycle. Then its element i enters the unit in cycle T+i and leaves it in cycle T+i+3. In cycle T+i+4 the outputs are `fw_s_en`=1, `fw_s_idx`=i and `fw_s_flags` equal to the value that `pipe_flags_s` had in cycle T+i+3. The flag bits are, from bit 0 upward: inexact, underflow, overflow, divide-by-zero, invalid.
- R3: Suppose a divide (`issue_cls` = 1) is accepted in cycle T. Then its element i enters the unit in cycle T+8i and leaves it in cycle T+8i+10. In cycle T+8i+11 the outputs are `fw_d_en`=1, `fw_d_idx`=i and `fw_d_flags` equal to the value that `pipe_flags_d` had in cycle T+8i+10.
- R4: `exc_raise` is high for exactly the cycle in which an instruction's last flag write appears, and only if the OR of (flags & ~`exc_mask`) over all that instruction's elements is nonzero. `exc_cause` equals that OR in that cycle and is 0 otherwise. Masked flags are still written.
- R5: In deferred mode (`precise_mode`=0), a simple-class request that arrives while no earlier instruction is still issuing elements is never stalled, whatever is in flight.
- R6: While an accepted instruction still has elements left to issue, `issue_stall` is 1. For a simple-class instruction of length V accepted in cycle T, this covers cycles T+1 to T+V-1.
- R7: After a divide element enters the unit in cycle c, a divide request is stalled in cycles c+1 to c+7 and can be accepted from cycle c+8. A simple-class request in that window is not stalled by it.
- R8: In precise mode, `issue_stall` stays 1 while any element is still inside the unit. It is released in the cycle in which the last element's flag write (and the exception pulse, if any) appears.
- R9: An instruction with `issue_vl` = 0 is accepted, issues no element, produces no flag write and no exception, and leaves issue unstalled in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| precise_mode | input | 1 | Mode control bit: 1 = precise mode, 0 = deferred mode |
| exc_mask | input | 5 | Per-flag disable for the exception pulse |
| issue_valid | input | 1 | Instruction issue request |
| issue_cls | input | 1 | Operation class: 0 = simple, 1 = divide |
| issue_vl | input | 7 | Vector length, 0 to 64 |
| pipe_flags_s | input | 5 | Flags of the simple-class element leaving the unit this cycle |
| pipe_flags_d | input | 5 | Flags of the divide element leaving the unit this cycle |
| issue_stall | output | 1 | Issue request is held this cycle |
| fw_s_en | output | 1 | Flag register write for a simple-class element |
| fw_s_idx | output | 6 | Element index of that write |
| fw_s_flags | output | 5 | Flags written |
| fw_d_en | output | 1 | Flag register write for a divide element |
| fw_d_idx | output | 6 | Element index of that write |
| fw_d_flags | output | 5 | Flags written |
| exc_raise | output | 1 | One-cycle exception pulse at the end of an instruction |
| exc_cause | output | 5 | OR of the unmasked flags of that instruction |

## Verification
`issue_stall` is combinational on the current state and the request, so the bench reads it shortly after driving the inputs, within the same cycle. Each flag write is due one cycle after its element leaves the unit: four cycles after the element enters for the simple class, and eleven cycles after it enters for a divide. Divide elements enter eight cycles apart. The bench derives every expected write, index, flag value and pulse from the acceptance cycle using these offsets. It compares all outputs at every falling edge across the whole window, so a write or pulse that arrives one cycle early or late is also caught.

// File: rtl/vfpx_pkg.sv
package vfpx_pkg;
    localparam int MAX_VL     = 64;
    localparam int VL_W       = $clog2(MAX_VL + 1);
    localparam int IDX_W      = $clog2(MAX_VL);
    localparam int NFLAG      = 5;
    localparam int LAT_SIMPLE = 3;
    localparam int LAT_DIV    = 10;
    localparam int DIV_RPT    = 8;
    localparam int COOL_W     = $clog2(DIV_RPT);

    typedef enum logic {CLS_SIMPLE = 1'b0, CLS_DIV = 1'b1} op_cls_e;

    // bit0 inexact, bit1 underflow, bit2 overflow, bit3 div-by-zero, bit4 invalid
    typedef logic [NFLAG-1:0] fpflags_t;

    typedef struct packed {
        logic             valid;
        logic             last;
        logic [IDX_W-1:0] idx;
    } elem_t;

    function automatic fpflags_t live_flags(fpflags_t f, fpflags_t m);
        return f & ~m;
    endfunction
endpackage

// File: rtl/vfpx_sequencer.sv
module vfpx_sequencer
    import vfpx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            issue_valid,
    input  op_cls_e         issue_cls,
    input  logic [VL_W-1:0] issue_vl,
    input  logic            precise_mode,
    input  logic            inflight,
    output logic            issue_stall,
    output logic            seq_busy,
    output elem_t           elem,
    output op_cls_e         elem_cls
);
    logic [COOL_W-1:0] div_cool;
    op_cls_e           seq_cls;
    logic [IDX_W-1:0]  seq_idx;
    logic [IDX_W-1:0]  seq_last_idx;
    logic              div_block;
    logic              accept;
    logic              seq_go;

    assign div_block   = (div_cool != '0);
    assign issue_stall = seq_busy
                       | ((issue_cls == CLS_DIV) & div_block)
                       | (precise_mode & inflight);
    assign accept      = issue_valid & ~issue_stall;
    assign seq_go      = seq_busy & ((seq_cls == CLS_SIMPLE) | ~div_block);

    always_comb begin
        elem     = '0;
        elem_cls = seq_cls;
        if (accept && issue_vl != '0) begin
            elem.valid = 1'b1;
            elem.idx   = '0;
            elem.last  = (issue_vl == VL_W'(1));
            elem_cls   = issue_cls;
        end else if (seq_go) begin
            elem.valid = 1'b1;
            elem.idx   = seq_idx;
            elem.last  = (seq_idx == seq_last_idx);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cool     <= '0;
            seq_busy     <= 1'b0;
            seq_cls      <= CLS_SIMPLE;
            seq_idx      <= '0;
            seq_last_idx <= '0;
        end else begin
            if (elem.valid && elem_cls == CLS_DIV)
                div_cool <= COOL_W'(DIV_RPT - 1);
            else if (div_block)
                div_cool <= div_cool - COOL_W'(1);

            if (accept && issue_vl > VL_W'(1)) begin
                seq_busy     <= 1'b1;
                seq_cls      <= issue_cls;
                seq_idx      <= IDX_W'(1);
                seq_last_idx <= IDX_W'(issue_vl - VL_W'(1));
            end else if (seq_go) begin
                if (seq_idx == seq_last_idx)
                    seq_busy <= 1'b0;
                else
                    seq_idx <= seq_idx + IDX_W'(1);
            end
        end
    end

    // R6
    multi_elem_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !issue_stall && issue_vl > VL_W'(1)) |=> issue_stall);
endmodule

// File: rtl/vfpx_tracker.sv
module vfpx_tracker
    import vfpx_pkg::*;
#(
    parameter int LAT     = LAT_SIMPLE,
    parameter int MIN_GAP = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  elem_t            push,
    input  fpflags_t         flags_in,
    input  fpflags_t         mask,
    output logic             busy,
    output logic             fw_en,
    output logic [IDX_W-1:0] fw_idx,
    output fpflags_t         fw_flags,
    output logic             raise,
    output fpflags_t         cause
);
    elem_t    stage [LAT];
    elem_t    exit_e;
    fpflags_t acc;
    fpflags_t cur;
    fpflags_t total;

    assign exit_e = stage[LAT-1];
    assign cur    = live_flags(flags_in, mask);
    assign total  = acc | cur;

    always_comb begin
        busy = 1'b0;
        for (int k = 0; k < LAT; k++) busy = busy | stage[k].valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < LAT; k++) stage[k] <= '0;
            acc      <= '0;
            fw_en    <= 1'b0;
            fw_idx   <= '0;
            fw_flags <= '0;
            raise    <= 1'b0;
            cause    <= '0;
        end else begin
            stage[0] <= push;
            for (int k = 1; k < LAT; k++) stage[k] <= stage[k-1];
            fw_en    <= exit_e.valid;
            fw_idx   <= exit_e.idx;
            fw_flags <= exit_e.valid ? flags_in : '0;
            raise    <= 1'b0;
            cause    <= '0;
            if (exit_e.valid) begin
                if (exit_e.last) begin
                    raise <= (total != '0);
                    cause <= total;
                    acc   <= '0;
                end else begin
                    acc <= total;
                end
            end
        end
    end

    generate
        if (MIN_GAP > 1) begin : g_gap
            logic [7:0] gap_cnt;
            always_ff @(posedge clk) begin
                if (rst)                gap_cnt <= 8'hFF;
                else if (exit_e.valid)  gap_cnt <= '0;
                else if (gap_cnt != 8'hFF) gap_cnt <= gap_cnt + 8'd1;
            end
            // R7
            div_spacing_chk: assert property (@(posedge clk) disable iff (rst)
                exit_e.valid |-> (gap_cnt >= 8'(MIN_GAP - 1)));
        end
    endgenerate

    // R4
    raise_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        raise |-> fw_en);
endmodule

// File: rtl/vfpx_ctrl.sv
module vfpx_ctrl
    import vfpx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             precise_mode,
    input  logic [NFLAG-1:0] exc_mask,
    input  logic             issue_valid,
    input  logic             issue_cls,
    input  logic [VL_W-1:0]  issue_vl,
    input  logic [NFLAG-1:0] pipe_flags_s,
    input  logic [NFLAG-1:0] pipe_flags_d,
    output logic             issue_stall,
    output logic             fw_s_en,
    output logic [IDX_W-1:0] fw_s_idx,
    output logic [NFLAG-1:0] fw_s_flags,
    output logic             fw_d_en,
    output logic [IDX_W-1:0] fw_d_idx,
    output logic [NFLAG-1:0] fw_d_flags,
    output logic             exc_raise,
    output logic [NFLAG-1:0] exc_cause
);
    elem_t            elem;
    op_cls_e          elem_cls;
    logic             seq_busy;
    logic             inflight;
    logic             trk_busy  [2];
    logic             trk_en    [2];
    logic [IDX_W-1:0] trk_idx   [2];
    fpflags_t         trk_flags [2];
    logic             trk_raise [2];
    fpflags_t         trk_cause [2];

    vfpx_sequencer u_seq (
        .clk          (clk),
        .rst          (rst),
        .issue_valid  (issue_valid),
        .issue_cls    (op_cls_e'(issue_cls)),
        .issue_vl     (issue_vl),
        .precise_mode (precise_mode),
        .inflight     (inflight),
        .issue_stall  (issue_stall),
        .seq_busy     (seq_busy),
        .elem         (elem),
        .elem_cls     (elem_cls)
    );

    generate
        for (genvar k = 0; k < 2; k++) begin : g_cls
            localparam op_cls_e MY_CLS = (k == 1) ? CLS_DIV : CLS_SIMPLE;
            localparam int      LAT    = (k == 1) ? LAT_DIV : LAT_SIMPLE;
            localparam int      GAP    = (k == 1) ? DIV_RPT : 1;
            elem_t    push_e;
            fpflags_t fin;
            assign push_e = (elem.valid && elem_cls == MY_CLS) ? elem : '0;
            assign fin    = (k == 1) ? pipe_flags_d : pipe_flags_s;
            vfpx_tracker #(.LAT(LAT), .MIN_GAP(GAP)) u_trk (
                .clk      (clk),
                .rst      (rst),
                .push     (push_e),
                .flags_in (fin),
                .mask     (exc_mask),
                .busy     (trk_busy[k]),
                .fw_en    (trk_en[k]),
                .fw_idx   (trk_idx[k]),
                .fw_flags (trk_flags[k]),
                .raise    (trk_raise[k]),
                .cause    (trk_cause[k])
            );
        end
    endgenerate

    assign inflight   = trk_busy[0] | trk_busy[1];
    assign fw_s_en    = trk_en[0];
    assign fw_s_idx   = trk_idx[0];
    assign fw_s_flags = trk_flags[0];
    assign fw_d_en    = trk_en[1];
    assign fw_d_idx   = trk_idx[1];
    assign fw_d_flags = trk_flags[1];
    assign exc_raise  = trk_raise[0] | trk_raise[1];
    assign exc_cause  = trk_cause[0] | trk_cause[1];

    // R8
    precise_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (precise_mode && inflight) |-> issue_stall);
    // R5
    deferred_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (!precise_mode && !seq_busy && issue_valid && !issue_cls) |-> !issue_stall);
    // R4
    cause_needs_raise_chk: assert property (@(posedge clk) disable iff (rst)
        !exc_raise |-> (exc_cause == '0));
    // R4
    raise_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        exc_raise |-> (exc_cause != '0));
endmodule

// File: tb/vfpx_ctrl_tb.sv
`timescale 1ns/1ps
module vfpx_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       precise_mode = 1'b0;
    logic [4:0] exc_mask = '0;
    logic       issue_valid = 1'b0;
    logic       issue_cls = 1'b0;
    logic [6:0] issue_vl = '0;
    logic [4:0] pipe_flags_s = '0;
    logic [4:0] pipe_flags_d = '0;
    logic       issue_stall;
    logic       fw_s_en, fw_d_en, exc_raise;
    logic [5:0] fw_s_idx, fw_d_idx;
    logic [4:0] fw_s_flags, fw_d_flags, exc_cause;

    int cyc = 0;
    int seed = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    vfpx_ctrl u_dut (
        .clk(clk), .rst(rst), .precise_mode(precise_mode), .exc_mask(exc_mask),
        .issue_valid(issue_valid), .issue_cls(issue_cls), .issue_vl(issue_vl),
        .pipe_flags_s(pipe_flags_s), .pipe_flags_d(pipe_flags_d),
        .issue_stall(issue_stall), .fw_s_en(fw_s_en), .fw_s_idx(fw_s_idx),
        .fw_s_flags(fw_s_flags), .fw_d_en(fw_d_en), .fw_d_idx(fw_d_idx),
        .fw_d_flags(fw_d_flags), .exc_raise(exc_raise), .exc_cause(exc_cause)
    );

    function automatic logic [4:0] fs(int n, int sd);
        return (((n * 7 + sd) % 13) < 3) ? (5'b1 << ((n + sd) % 5)) : 5'b0;
    endfunction
    function automatic logic [4:0] fd(int n, int sd);
        return (((n + sd) % 3) == 0) ? (5'b1 << ((n * 3 + sd) % 5)) : 5'b0;
    endfunction

    always @(negedge clk) begin
        pipe_flags_s <= fs(cyc, seed);
        pipe_flags_d <= fd(cyc, seed);
    end

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        while (cyc < n) @(negedge clk);
    endtask

    // issue one instruction; returns acceptance cycle
    task automatic issue_one(bit prec, bit cls, int vl, output int t);
        @(negedge clk);
        precise_mode = prec;
        issue_cls = cls;
        issue_vl = 7'(vl);
        issue_valid = 1'b1;
        #1;
        while (issue_stall) begin
            @(negedge clk);
            #1;
        end
        t = cyc;
        @(negedge clk);
        issue_valid = 1'b0;
    endtask

    task automatic stall_at(int n, bit cls, bit exp, string req);
        wait_cyc(n);
        issue_cls = cls;
        #1;
        check(issue_stall == exp, req, issue_stall, exp);
    endtask

    typedef struct packed {
        logic       prec;
        logic       cls;
        logic [6:0] vl;
        logic [4:0] mask;
        logic [7:0] sd;
    } row_t;

    localparam int NROW = 9;
    localparam row_t ROWS [NROW] = '{
        '{1'b0, 1'b0, 7'd1,  5'h00, 8'd0},
        '{1'b0, 1'b0, 7'd8,  5'h00, 8'd3},
        '{1'b0, 1'b0, 7'd64, 5'h00, 8'd11},
        '{1'b0, 1'b0, 7'd16, 5'h1F, 8'd5},
        '{1'b0, 1'b1, 7'd1,  5'h00, 8'd1},
        '{1'b0, 1'b1, 7'd5,  5'h03, 8'd2},
        '{1'b1, 1'b0, 7'd6,  5'h00, 8'd7},
        '{1'b1, 1'b1, 7'd3,  5'h10, 8'd4},
        '{1'b0, 1'b0, 7'd20, 5'h0C, 8'd9}
    };

    task automatic run_row(row_t r);
        int t, endc, vl;
        logic [4:0] acc;
        bit bad;
        string tag;
        vl = int'(r.vl);
        seed = int'(r.sd);
        exc_mask = r.mask;
        acc = '0;
        bad = 0;
        tag = r.cls ? (r.prec ? "R3/R4/R8" : "R3/R4") : (r.prec ? "R2/R4/R8" : "R2/R4");
        issue_one(r.prec, r.cls, vl, t);
        endc = r.cls ? (8 * (vl - 1) + 13) : (vl + 6);
        for (int n = t + 1; n <= t + endc; n++) begin
            bit es, ed, er;
            int ei, k, d;
            logic [4:0] ef, ec;
            wait_cyc(n);
            es = 0; ed = 0; er = 0; ei = 0; ef = '0; ec = '0;
            k = n - t - 4;
            d = n - t - 11;
            if (!r.cls && k >= 0 && k < vl) begin
                es = 1; ei = k; ef = fs(n - 1, seed);
            end
            if (r.cls && d >= 0 && (d % 8) == 0 && (d / 8) < vl) begin
                ed = 1; ei = d / 8; ef = fd(n - 1, seed);
            end
            if (es || ed) begin
                acc = acc | (ef & ~r.mask);
                if (ei == vl - 1) begin
                    er = (acc != '0);
                    ec = acc;
                end
            end
            if (!bad) begin
                if (fw_s_en !== es || fw_d_en !== ed) begin
                    bad = 1;
                    $display("FAIL %s cycle+%0d write enable actual=%0d%0d expected=%0d%0d",
                             tag, n - t, fw_s_en, fw_d_en, es, ed);
                end else if (es && (fw_s_idx != 6'(ei) || fw_s_flags != ef)) begin
                    bad = 1;
                    $display("FAIL %s simple write actual=%0d/%0h expected=%0d/%0h",
                             tag, fw_s_idx, fw_s_flags, ei, ef);
                end else if (ed && (fw_d_idx != 6'(ei) || fw_d_flags != ef)) begin
                    bad = 1;
                    $display("FAIL %s divide write actual=%0d/%0h expected=%0d/%0h",
                             tag, fw_d_idx, fw_d_flags, ei, ef);
                end else if (exc_raise !== er || exc_cause !== ec) begin
                    bad = 1;
                    $display("FAIL %s raise actual=%0d/%0h expected=%0d/%0h",
                             tag, exc_raise, exc_cause, er, ec);
                end
            end
        end
        n_chk++;
        if (bad) n_fail++;
    endtask

    initial begin
        #600000;
        if (!done) begin
            done = 1;
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int t;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(issue_stall == 1'b0, "R1 stall", issue_stall, 0);
        check(!fw_s_en && !fw_d_en, "R1 writes", fw_s_en | fw_d_en, 0);
        check(exc_raise == 1'b0, "R1 raise", exc_raise, 0);
        check(exc_cause == 5'b0, "R1 cause", exc_cause, 0);

        for (int i = 0; i < NROW; i++) begin
            run_row(ROWS[i]);
            repeat (2) @(negedge clk);
        end

        // R6: elements still issuing hold the next request
        issue_one(1'b0, 1'b0, 4, t);
        stall_at(t + 1, 1'b0, 1'b1, "R6 first");
        stall_at(t + 3, 1'b0, 1'b1, "R6 last");
        stall_at(t + 4, 1'b0, 1'b0, "R6 release");
        repeat (12) @(negedge clk);

        // R5: deferred mode never stalls on in-flight work
        issue_one(1'b0, 1'b0, 1, t);
        stall_at(t + 1, 1'b0, 1'b0, "R5 inflight");
        stall_at(t + 2, 1'b0, 1'b0, "R5 inflight2");
        repeat (12) @(negedge clk);

        // R8: precise mode, simple op
        issue_one(1'b1, 1'b0, 1, t);
        stall_at(t + 3, 1'b0, 1'b1, "R8 simple hold");
        stall_at(t + 4, 1'b0, 1'b0, "R8 simple release");
        repeat (12) @(negedge clk);

        // R8: precise mode, divide
        issue_one(1'b1, 1'b1, 1, t);
        stall_at(t + 10, 1'b0, 1'b1, "R8 div hold");
        stall_at(t + 11, 1'b0, 1'b0, "R8 div release");
        precise_mode = 1'b0;
        repeat (12) @(negedge clk);

        // R7: divide spacing
        issue_one(1'b0, 1'b1, 1, t);
        stall_at(t + 1, 1'b0, 1'b0, "R7 simple free");
        stall_at(t + 7, 1'b1, 1'b1, "R7 div hold");
        stall_at(t + 8, 1'b1, 1'b0, "R7 div release");
        issue_cls = 1'b0;
        repeat (20) @(negedge clk);

        // R9: zero-length instruction
        issue_one(1'b0, 1'b0, 0, t);
        stall_at(t + 1, 1'b1, 1'b0, "R9 stall");
        begin
            bit seen = 0;
            for (int n = t + 1; n <= t + 15; n++) begin
                wait_cyc(n);
                if (fw_s_en || fw_d_en || exc_raise) seen = 1;
            end
            check(!seen, "R9 no write", seen, 0);
        end

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule